// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Unit

This unit turns up to eight already-selected general-purpose input pins into eight interrupt lines. Each channel works in one of two modes. In edge mode the channel records rising and falling transitions in two sticky flags. Each transition type has its own enable, so a channel can react to one edge or to both. In level mode the channel reports the live pin level against a chosen polarity, gated by an on/off enable.

Software uses a small 32-bit register window. The mode and the two enable vectors can be loaded directly. They can also be changed bit by bit through write-one set and clear addresses, so one channel can be updated without a read-modify-write. The falling-enable vector has a second role: in level mode it selects the active polarity. Edge flags are cleared by writing ones to the status address, or separately to the rise or fall flag address. Output bit k feeds parent interrupt number 32 + k.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset every register reads 0 and every interrupt output is low.
- R2: A write to 0x08 (or 0x14) sets each rising (or falling) enable bit whose data bit is 1. A write to 0x0C (or 0x18) clears each such bit. Data bits that are 0 leave their enable bit unchanged. The enables read back at 0x04 and 0x10.
- R3: A write to 0x00 (mode, 1 = level, 0 = edge), 0x04 (rising/level enable) or 0x10 (falling enable / polarity) loads the whole vector, and the vector reads back at the same offset.
- R4: In edge mode, a rising pin transition sets rise flag k (read at 0x1C) only if rising enable k is 1. The flag and interrupt k appear three clock edges after the pin changes.
- R5: In edge mode, a falling pin transition sets fall flag k (read at 0x20) only if falling enable k is 1. A channel with both enables set records both edges.
- R6: Writing 1 to status bit k (0x24) clears both edge flags of channel k. Zero bits and other channels are left alone.
- R7: Writing 1 to bit k at 0x1C clears only rise flag k. Writing 1 to bit k at 0x20 clears only fall flag k.
- R8: If an enabled edge is detected in the same cycle as a write that clears its flag, the flag ends up set. A flag of the other edge type that the same write clears is still cleared.
- R9: In level mode, status k equals rising enable k AND (synchronised pin == falling enable k), two edges after a pin change. Clear writes to the status address have no effect on it.
- R10: Interrupt output bit k equals status bit k (0x24), and it is the line for parent number 32 + k.
- R11: A channel in level mode never sets its edge flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 8 | Asynchronous pin inputs, one per channel |
| irq_out | output | 8 | Interrupt lines; bit k goes to parent number 32 + k |

## Verification
Edge capture and the software flag clear can land on the same clock edge, and that collision decides whether an interrupt is lost. The bench drives a rising pin transition and times a status-clear write so that its clock edge is the one on which the synchronised edge is detected. The channel also holds a previously captured fall flag at that moment. The bench then expects the rise flag and interrupt to be set and the old fall flag to be gone, so the test shows that the set takes priority and that the clear still acts on the other flag.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_MODE     = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_RISE_HIT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_FALL_HIT = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 6'h24;

  typedef struct packed {
    logic mode_ld;
    logic ren_ld;
    logic ren_set;
    logic ren_clr;
    logic fen_ld;
    logic fen_set;
    logic fen_clr;
    logic rhit_clr;
    logic fhit_clr;
    logic stat_clr;
  } wr_dec_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d_in;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_cfg.sv
module pin_irq_cfg
  import pin_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wbits,
  output logic [NCH-1:0]    mode,
  output logic [NCH-1:0]    ren,
  output logic [NCH-1:0]    fen,
  output logic [NCH-1:0]    rclr,
  output logic [NCH-1:0]    fclr
);
  wr_dec_t dec;
  logic [NCH-1:0] mode_q, mode_d, ren_q, ren_d, fen_q, fen_d;
  logic mode_ce, ren_ce, fen_ce;

  always_comb begin
    dec = '0;
    if (wr_en) begin
      dec.mode_ld  = (addr == OFS_MODE);
      dec.ren_ld   = (addr == OFS_RISE_EN);
      dec.ren_set  = (addr == OFS_RISE_SET);
      dec.ren_clr  = (addr == OFS_RISE_CLR);
      dec.fen_ld   = (addr == OFS_FALL_EN);
      dec.fen_set  = (addr == OFS_FALL_SET);
      dec.fen_clr  = (addr == OFS_FALL_CLR);
      dec.rhit_clr = (addr == OFS_RISE_HIT);
      dec.fhit_clr = (addr == OFS_FALL_HIT);
      dec.stat_clr = (addr == OFS_STATUS);
    end
  end

  always_comb begin
    mode_ce = dec.mode_ld;
    ren_ce  = dec.ren_ld | dec.ren_set | dec.ren_clr;
    fen_ce  = dec.fen_ld | dec.fen_set | dec.fen_clr;
    mode_d  = wbits;
    if (dec.ren_ld)       ren_d = wbits;
    else if (dec.ren_set) ren_d = ren_q | wbits;
    else                  ren_d = ren_q & ~wbits;
    if (dec.fen_ld)       fen_d = wbits;
    else if (dec.fen_set) fen_d = fen_q | wbits;
    else                  fen_d = fen_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else begin
      if (mode_ce) mode_q <= mode_d;
      if (ren_ce)  ren_q  <= ren_d;
      if (fen_ce)  fen_q  <= fen_d;
    end
  end

  assign mode = mode_q;
  assign ren  = ren_q;
  assign fen  = fen_q;
  assign rclr = (dec.rhit_clr | dec.stat_clr) ? wbits : '0;
  assign fclr = (dec.fhit_clr | dec.stat_clr) ? wbits : '0;
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic level_mode,
  input  logic ren,
  input  logic fen,
  input  logic rclr,
  input  logic fclr,
  output logic rhit,
  output logic fhit,
  output logic stat
);
  logic prev_q;
  logic rhit_q, rhit_d, fhit_q, fhit_d;
  logic rise_det, fall_det, rset, fset;

  always_comb begin
    rise_det = pin_s & ~prev_q;
    fall_det = ~pin_s & prev_q;
    rset     = rise_det & ren & ~level_mode;
    fset     = fall_det & fen & ~level_mode;
    rhit_d   = rset | (rhit_q & ~rclr);
    fhit_d   = fset | (fhit_q & ~fclr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rhit_q <= 1'b0;
      fhit_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (rset | rclr) rhit_q <= rhit_d;
      if (fset | fclr) fhit_q <= fhit_d;
    end
  end

  assign rhit = rhit_q;
  assign fhit = fhit_q;
  assign stat = level_mode ? (ren & ~(pin_s ^ fen)) : (rhit_q | fhit_q);
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    irq_out
);
  logic [1:0]     rst_pipe_q;
  logic           rst_sync_n;
  logic [NCH-1:0] pin_s, mode_w, ren_w, fen_w, rclr_w, fclr_w;
  logic [NCH-1:0] rhit_w, fhit_w, stat_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pin_irq_sync #(.W(NCH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_in(pin_in), .q_out(pin_s)
  );

  pin_irq_cfg #(.NCH(NCH)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
    .wbits(wdata[NCH-1:0]), .mode(mode_w), .ren(ren_w), .fen(fen_w),
    .rclr(rclr_w), .fclr(fclr_w)
  );

  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_ch
      pin_irq_chan u_chan (
        .clk(clk), .rst_n(rst_sync_n), .pin_s(pin_s[k]),
        .level_mode(mode_w[k]), .ren(ren_w[k]), .fen(fen_w[k]),
        .rclr(rclr_w[k]), .fclr(fclr_w[k]),
        .rhit(rhit_w[k]), .fhit(fhit_w[k]), .stat(stat_w[k])
      );
    end
  endgenerate

  assign irq_out = stat_w;

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MODE:     rdata[NCH-1:0] = mode_w;
      OFS_RISE_EN:  rdata[NCH-1:0] = ren_w;
      OFS_FALL_EN:  rdata[NCH-1:0] = fen_w;
      OFS_RISE_HIT: rdata[NCH-1:0] = rhit_w;
      OFS_FALL_HIT: rdata[NCH-1:0] = fhit_w;
      OFS_STATUS:   rdata[NCH-1:0] = stat_w;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_irq_unit_chk.sv
module pin_irq_unit_chk
  import pin_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NCH-1:0]    mode,
  input logic [NCH-1:0]    ren,
  input logic [NCH-1:0]    rhit,
  input logic [NCH-1:0]    fhit,
  input logic [NCH-1:0]    irq
);
  assert_set_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_RISE_SET) |=>
      ((ren & $past(wdata[NCH-1:0])) == $past(wdata[NCH-1:0])));

  assert_clr_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_RISE_CLR) |=> ((ren & $past(wdata[NCH-1:0])) == '0));

  assert_rise_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rhit & ~$past(rhit) & ($past(mode) | ~$past(ren))) == '0));

  assert_level_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (((rhit | fhit) & ~$past(rhit | fhit) & $past(mode)) == '0));

  assert_edge_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (($past(irq) & ~irq & ~mode & ~$past(mode)) == '0));
endmodule

bind pin_irq_unit pin_irq_unit_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode(mode_w), .ren(ren_w), .rhit(rhit_w), .fhit(fhit_w), .irq(irq_out)
);

// File: tb/pin_irq_unit_bench.sv
`timescale 1ns/1ps
module pin_irq_unit_bench;
  import pin_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       req;
    bit          is_irq;
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pin_irq_unit u_pin_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  // Monitor: pops expected items 1 ns after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {24'h0, irq_out} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic chk_rd(input string req, input logic [5:0] a, input logic [31:0] e);
    item_t it;
    addr = a;
    it.req = req; it.is_irq = 1'b0; it.exp = e;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input string req, input logic [7:0] e);
    item_t it;
    it.req = req; it.is_irq = 1'b1; it.exp = {24'h0, e};
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk_irq("R1", 8'h00);
    chk_rd("R1", OFS_MODE, 32'h0);
    chk_rd("R1", OFS_RISE_EN, 32'h0);
    chk_rd("R1", OFS_FALL_EN, 32'h0);
    chk_rd("R1", OFS_STATUS, 32'h0);
    // R3 direct loads
    wr(OFS_MODE, 32'hF0);    chk_rd("R3", OFS_MODE, 32'hF0);
    wr(OFS_MODE, 32'h00);
    wr(OFS_RISE_EN, 32'hFF); chk_rd("R3", OFS_RISE_EN, 32'hFF);
    wr(OFS_RISE_EN, 32'h00);
    wr(OFS_FALL_EN, 32'h81); chk_rd("R3", OFS_FALL_EN, 32'h81);
    wr(OFS_FALL_EN, 32'h00);
    // R2 write-one set and clear
    wr(OFS_RISE_SET, 32'h05); chk_rd("R2", OFS_RISE_EN, 32'h05);
    wr(OFS_RISE_SET, 32'h02); chk_rd("R2", OFS_RISE_EN, 32'h07);
    wr(OFS_RISE_CLR, 32'h04); chk_rd("R2", OFS_RISE_EN, 32'h03);
    wr(OFS_FALL_SET, 32'h0A); chk_rd("R2", OFS_FALL_EN, 32'h0A);
    wr(OFS_FALL_CLR, 32'h08); chk_rd("R2", OFS_FALL_EN, 32'h02);
    // R4 rising edge, enabled channel 0
    pin_in = 8'h01; step(3);
    chk_irq("R4", 8'h01);
    chk_rd("R4", OFS_RISE_HIT, 32'h01);
    chk_rd("R4", OFS_FALL_HIT, 32'h00);
    // R4 rising edge on disabled channel 2 is not captured
    pin_in = 8'h05; step(3);
    chk_irq("R4", 8'h01);
    chk_rd("R4", OFS_RISE_HIT, 32'h01);
    // R5 both edges on channel 1
    pin_in = 8'h07; step(3);
    pin_in = 8'h05; step(3);
    chk_rd("R5", OFS_FALL_HIT, 32'h02);
    chk_rd("R5", OFS_RISE_HIT, 32'h03);
    chk_irq("R5", 8'h03);
    pin_in = 8'h04; step(3);   // channel 0 falls, fall enable 0 is off
    chk_rd("R5", OFS_FALL_HIT, 32'h02);
    // R6 status clear
    wr(OFS_STATUS, 32'h02);
    chk_irq("R6", 8'h01);
    chk_rd("R6", OFS_RISE_HIT, 32'h01);
    chk_rd("R6", OFS_FALL_HIT, 32'h00);
    wr(OFS_STATUS, 32'h00);
    chk_irq("R6", 8'h01);
    // R7 separate flag clears
    pin_in = 8'h06; step(3);
    pin_in = 8'h04; step(3);
    chk_rd("R7", OFS_RISE_HIT, 32'h03);
    wr(OFS_RISE_HIT, 32'h02);
    chk_rd("R7", OFS_RISE_HIT, 32'h01);
    chk_rd("R7", OFS_FALL_HIT, 32'h02);
    chk_irq("R7", 8'h03);
    wr(OFS_FALL_HIT, 32'h02);
    chk_rd("R7", OFS_FALL_HIT, 32'h00);
    chk_irq("R7", 8'h01);
    wr(OFS_STATUS, 32'h01);
    chk_irq("R6", 8'h00);
    // R8 edge detected on the same edge as a clearing write
    pin_in = 8'h06; step(3);
    pin_in = 8'h04; step(3);
    wr(OFS_RISE_HIT, 32'h02);  // only fall flag of channel 1 remains
    chk_rd("R8", OFS_FALL_HIT, 32'h02);
    pin_in = 8'h06; step(2);
    wr(OFS_STATUS, 32'h02);
    chk_rd("R8", OFS_RISE_HIT, 32'h02);
    chk_rd("R8", OFS_FALL_HIT, 32'h00);
    chk_irq("R8", 8'h02);
    wr(OFS_STATUS, 32'h02);
    chk_irq("R8", 8'h00);
    // R9 level mode on channel 3, active high
    wr(OFS_MODE, 32'h08);
    wr(OFS_RISE_SET, 32'h08);
    wr(OFS_FALL_SET, 32'h08);
    chk_irq("R9", 8'h00);
    pin_in = 8'h0E; step(2);
    chk_irq("R9", 8'h08);
    wr(OFS_STATUS, 32'h08);
    chk_irq("R9", 8'h08);
    wr(OFS_FALL_CLR, 32'h08);  // active low now, pin high
    chk_irq("R9", 8'h00);
    pin_in = 8'h06; step(2);
    chk_irq("R9", 8'h08);
    wr(OFS_RISE_CLR, 32'h08);
    chk_irq("R9", 8'h00);
    // R11 no edge flags from a level channel
    chk_rd("R11", OFS_RISE_HIT, 32'h00);
    chk_rd("R11", OFS_FALL_HIT, 32'h00);
    // R10 channel 7 drives output bit 7 (parent line 39)
    wr(OFS_RISE_SET, 32'h80);
    pin_in = 8'h86; step(3);
    chk_irq("R10", 8'h80);
    chk_rd("R10", OFS_STATUS, 32'h80);
    step(2);
    done = 1;
    summary();
    $finish;
  end
endmodule